// File: doc/BRIEF.md
# Dual-Path Bus Register

This block carries a 12-bit data word to two identical output buses. Each data bit drives one line of each bus. A mode input selects the source of the outputs. In register mode the outputs show a bank of positive-edge flip-flops. In buffer mode the data inputs pass straight through to the outputs with no clocking.

The flip-flops are split into a lower group of eight bits and an upper group of four bits. A load-select input picks which groups capture data on a rising clock edge. When it is low, every bit captures. When it is high, only the upper group captures and the lower group keeps its value. This lets a bus master refresh the four high bits on their own, without rewriting the rest of the word.

A single active-low output enable drives both buses to high impedance. It has no effect on the stored contents, so data can be held or loaded while the buses float. A synchronous active-high reset clears the flip-flops.

Top module: `dual_path_bus_reg`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, every stored bit becomes 0.
- R2: With `mode_buf` low, both buses show the stored word, and that word changes only at a rising edge of `clk`.
- R3: When `upper_only` is 0 at a rising edge (and `rst` is low), all 12 stored bits take the value of `data_in`.
- R4: When `upper_only` is 1 at a rising edge (and `rst` is low), stored bits [11:8] take `data_in[11:8]` and stored bits [7:0] keep their previous value.
- R5: With `mode_buf` high and `oe_n` low, both buses equal `data_in` in the same cycle, without waiting for a clock edge.
- R6: The flip-flops keep loading under R3/R4 while `mode_buf` is high. After `mode_buf` returns low, the buses show the word last captured.
- R7: While `oe_n` is low, `out_a` and `out_b` always carry identical values.
- R8: While `oe_n` is high, all 24 output lines are high impedance (`z`).
- R9: `oe_n` has no effect on loading or holding. A word captured while `oe_n` is high appears once `oe_n` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flip-flops capture on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_buf | input | 1 | 1 = buffer (pass-through), 0 = register output |
| upper_only | input | 1 | 1 = only bits [11:8] load; 0 = all bits load |
| oe_n | input | 1 | Output enable, active low; 1 floats both buses |
| data_in | input | 12 | Data word |
| out_a | output | 12 | First output copy |
| out_b | output | 12 | Second output copy |

## Verification
The bench targets the split load. It loads a full word, then applies a new word with `upper_only` high. A design that ignored the split, or reversed the groups, would show new values in bits [7:0] or stale values in bits [11:8].

It also loads words while in buffer mode and while the buses float, then switches back. A design that froze the flip-flops in either state would show an old word after the switch. A design that registered the buffer path would show the bus lagging `data_in` by one cycle.

Every sample compares both copies against the same expected value. A broken second copy, or a bus that stays driven when disabled, is therefore caught.

// File: rtl/dual_path_bus_reg.sv
module dual_path_bus_reg #(
  parameter int WIDTH   = 12,
  parameter int HI_BITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_buf,
  input  logic             upper_only,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] out_a,
  output logic [WIDTH-1:0] out_b
);
  localparam int LO_BITS = WIDTH - HI_BITS;

  logic [WIDTH-1:0] store;
  logic [WIDTH-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      store <= '0;
    end else begin
      store[WIDTH-1:LO_BITS] <= data_in[WIDTH-1:LO_BITS];
      if (!upper_only) store[LO_BITS-1:0] <= data_in[LO_BITS-1:0];
    end
  end

  assign sel   = mode_buf ? data_in : store;
  assign out_a = oe_n ? {WIDTH{1'bz}} : sel;
  assign out_b = oe_n ? {WIDTH{1'bz}} : sel;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> store == '0);

  // R3
  full_load_chk: assert property (@(posedge clk) disable iff (rst)
    !upper_only |=> store == $past(data_in));

  // R4
  upper_load_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> store[WIDTH-1:LO_BITS] == $past(data_in[WIDTH-1:LO_BITS]));

  // R4
  lower_hold_chk: assert property (@(posedge clk) disable iff (rst)
    upper_only |=> $stable(store[LO_BITS-1:0]));
endmodule

// File: tb/dual_path_bus_reg_bench.sv
`timescale 1ns/1ps
module dual_path_bus_reg_bench;
  localparam int W = 12;
  logic clk = 1'b0;
  logic rst = 1'b0, mode_buf = 1'b0, upper_only = 1'b0, oe_n = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] out_a, out_b;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] model = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  dual_path_bus_reg u_dual_path_bus_reg (
    .clk(clk), .rst(rst), .mode_buf(mode_buf), .upper_only(upper_only),
    .oe_n(oe_n), .data_in(data_in), .out_a(out_a), .out_b(out_b));

  function automatic logic [W-1:0] expected();
    if (oe_n) return {W{1'bz}};
    return mode_buf ? data_in : model;
  endfunction

  // Driver: apply inputs at the falling edge, advance the model at the rising edge, push the expected item.
  task automatic step(input logic r, input logic m, input logic u, input logic o,
                      input logic [W-1:0] d, input string tag);
    @(negedge clk);
    rst = r; mode_buf = m; upper_only = u; oe_n = o; data_in = d;
    @(posedge clk);
    if (r) model = '0;
    else begin
      model[W-1:8] = d[W-1:8];
      if (!u) model[7:0] = d[7:0];
    end
    exp_q.push_back(expected());
    tag_q.push_back(tag);
  endtask

  // Monitor: compare both copies 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      automatic logic [W-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      checks++;
      if (out_a !== e || out_b !== e) begin
        fails++;
        $display("FAIL %s: out_a=%b out_b=%b expected=%b", t, out_a, out_b, e);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, 12'hABC, "R1 reset clears");
    step(1, 0, 0, 0, 12'h123, "R1 reset held");
    step(0, 0, 0, 0, 12'hA5C, "R3 full load");
    step(0, 0, 0, 0, 12'h3C7, "R3 full load again");
    step(0, 0, 1, 0, 12'hF00, "R4 upper only, low kept");
    step(0, 0, 1, 0, 12'h0FF, "R4 lower ignored");
    step(0, 0, 1, 0, 12'h955, "R4 R7 upper only");
    step(0, 0, 0, 0, 12'hFFF, "R3 all ones");
    step(0, 0, 0, 0, 12'h000, "R3 all zeros");
    step(0, 1, 0, 0, 12'h5A5, "R5 buffer pass");
    step(0, 1, 1, 0, 12'hE1E, "R5 R6 buffer with upper load");
    // R2: register output steady through a mid-cycle data change
    step(0, 0, 1, 0, 12'h777, "R2 R6 back to register");
    @(negedge clk); data_in = 12'h111; #0.5;
    checks++;
    if (out_a !== model || out_b !== model) begin
      fails++; $display("FAIL R2 mid-cycle: out_a=%b out_b=%b expected=%b", out_a, out_b, model);
    end
    // R5: buffer responds within the cycle
    mode_buf = 1; data_in = 12'h2D4; #0.5;
    checks++;
    if (out_a !== 12'h2D4 || out_b !== 12'h2D4) begin
      fails++; $display("FAIL R5 combinational: out_a=%b out_b=%b expected=%b", out_a, out_b, 12'h2D4);
    end
    step(0, 0, 0, 1, 12'hC33, "R8 R9 float and load");
    step(0, 1, 1, 1, 12'h4B8, "R8 R9 float buffer upper load");
    step(0, 0, 1, 0, 12'h6EE, "R9 loaded while floating");
    step(0, 0, 0, 0, 12'h81F, "R7 R3 load");
    step(1, 1, 0, 1, 12'h81F, "R1 R8 reset while floating");
    step(0, 0, 1, 0, 12'h000, "R1 R4 zeros after reset");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule